// File: doc/BRIEF.md
# Strap-Configured Processor Bus Front End

This block connects an external 8-bit parallel processor bus to a 16-entry internal register space. It works in the system clock domain. It turns bus transactions into a single-cycle register write strobe and a level read enable. The enable comes with a read address and returns read data onto the shared data bus through a separate output-enable signal.

The bus style is set by strapping. While reset is asserted, the two lowest address pins are sampled, and the result selects one of three styles:
- a strobe-plus-direction style;
- a separate read/write strobe style with a demultiplexed address;
- the same separate-strobe style with address and data multiplexed. Here address pin 0 becomes the address latch enable.

The choice holds until the next reset.

Two register addresses are served inside the block: a pending-flag word and an interrupt-enable mask. Internal logic sets pending flags. Software clears a flag by writing a one to its bit. The active-low interrupt output follows any enabled, pending flag.

Top module: `busfront`

## Requirements
- R1: While `rstN` is low, the strap `{addrIn[1],addrIn[0]}` is captured: `11` selects strobe/direction mode, `10` selects multiplexed separate-strobe mode, and `00` or `01` selects demultiplexed separate-strobe mode. The mode does not change until reset is asserted again.
- R2: In both separate-strobe modes, a read is active while `csN` and `rdN` are both low, and a write is active while `csN` and `wrN` are both low.
- R3: In strobe/direction mode, `rdN` is the active-low data strobe and `wrN` is the direction (1 = read, 0 = write). A transaction is active while `csN` and the strobe are both low. A write never drives `dataOe`.
- R4: In multiplexed mode, `addrIn[0]` is the address latch enable. The register address is `dataIn[3:0]` as last sampled while the enable was high, and `addrIn[3:1]` are ignored.
- R5: A write produces exactly one `regWrStb` pulse of one clock. The pulse appears in the cycle after the first clock edge that sees the write inactive. It carries the address and data sampled in the last active cycle.
- R6: `dataOe` is high only while a read is active; the same holds for `regRdEn`. During a read, `regRdAddr` is the selected address and `dataOut` is that register's value; otherwise `dataOut` is zero.
- R7: A high bit on `pendSet` at a clock edge sets the matching pending flag. A read of address 0 returns the flags in the low bits.
- R8: Writing to address 0 clears each flag whose data bit is one. A flag that is set and cleared in the same cycle stays set.
- R9: Address 1 holds the interrupt mask, which is zero after reset and reads back as written. `irqN` is low exactly while some flag and its mask bit are both one.
- R10: Writes to addresses 0 and 1 are absorbed by the block and produce no `regWrStb`.
- R11: After reset, `dataOe` and `regWrStb` are low, `irqN` is high, and flags and mask read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset, also the strap sampling window |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, or data strobe in strobe/direction mode |
| wrN | input | 1 | Write strobe, or read/write direction in strobe/direction mode |
| addrIn | input | 4 | Register address; bits 1:0 are strap inputs in reset, bit 0 is the latch enable in multiplexed mode |
| dataIn | input | 8 | Incoming data bus (also the address in multiplexed mode) |
| dataOut | output | 8 | Outgoing read data |
| dataOe | output | 1 | Data bus output enable |
| irqN | output | 1 | Interrupt request, active low |
| pendSet | input | 8 | Per-flag set pulses from internal logic |
| regRdData | input | 8 | Read data from the external register space |
| regRdEn | output | 1 | Read in progress |
| regRdAddr | output | 4 | Address being read |
| regWrStb | output | 1 | Single-cycle register write strobe |
| regWrAddr | output | 4 | Write address, valid with the strobe |
| regWrData | output | 8 | Write data, valid with the strobe |

## Verification
The bench runs the same write and read traffic in every strap mode. It keeps changing the address pins after reset, so a mode register that follows the pins would misdecode later transactions. In strobe/direction mode, a design that took the strobe as a read would drive the bus during writes. In multiplexed mode, the junk on the upper address pins would appear on `regRdAddr`, or on the scoreboard's write addresses, if the latch were bypassed. The flag tests clear bits selectively and clear one bit in the same cycle it is set again. A clear-wins design would lose that event. Local writes to the flag and mask words must not reach the scoreboard, so a stray strobe shows up as an unexpected item.

// File: rtl/bif_pkg.sv
package bif_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_STRB  = 2'd1,
    MODE_MUX   = 2'd2
  } busMode_e;

  typedef struct packed {
    logic capture;  // write active this cycle: sample address and data
    logic commit;   // write just ended: issue the write
    logic readAct;  // read active: drive the bus
    logic muxMode;  // address comes from the latch-enable capture
  } busStrb_t;

  function automatic busMode_e decodeStrap(input logic [1:0] strap);
    case (strap)
      2'b11:   return MODE_STRB;
      2'b10:   return MODE_MUX;
      default: return MODE_SPLIT;
    endcase
  endfunction
endpackage

// File: rtl/bif_ctrl.sv
module bif_ctrl
  import bif_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     rdN,
  input  logic     wrN,
  input  logic [1:0] strapIn,
  output busStrb_t strb,
  output busMode_e busMode
);
  busMode_e modeQ;
  logic     wrPrev;
  logic     rdAct;
  logic     wrAct;

  always_comb begin
    if (modeQ == MODE_STRB) begin
      rdAct = !csN && !rdN && wrN;
      wrAct = !csN && !rdN && !wrN;
    end else begin
      rdAct = !csN && !rdN;
      wrAct = !csN && !wrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= decodeStrap(strapIn);
      wrPrev <= 1'b0;
    end else begin
      wrPrev <= wrAct;
    end
  end

  always_comb begin
    strb.capture = wrAct;
    strb.commit  = wrPrev && !wrAct;
    strb.readAct = rdAct;
    strb.muxMode = (modeQ == MODE_MUX);
  end

  assign busMode = modeQ;
endmodule

// File: rtl/bif_dpath.sv
module bif_dpath
  import bif_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int FLAG_W    = 8,
  parameter int FLAG_ADDR = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [FLAG_W-1:0] pendSet,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regRdAddr,
  output logic              regWrStb,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              irqN
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

  logic [ADDR_W-1:0] aleAddr, curAddr, wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [FLAG_W-1:0] flagQ, maskQ, clrVec;
  logic [DATA_W-1:0] flagWide, maskWide, rdMux;
  logic              hitFlag, hitMask;

  assign curAddr = strb.muxMode ? aleAddr : addrIn;
  assign hitFlag = (wrAddrQ == FLAG_A);
  assign hitMask = (wrAddrQ == MASK_A);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aleAddr <= '0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else begin
      if (strb.muxMode && addrIn[0]) aleAddr <= dataIn[ADDR_W-1:0];
      if (strb.capture) begin
        wrAddrQ <= curAddr;
        wrDataQ <= dataIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrStb  <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      maskQ     <= '0;
    end else begin
      regWrStb <= strb.commit && !hitFlag && !hitMask;
      if (strb.commit) begin
        regWrAddr <= wrAddrQ;
        regWrData <= wrDataQ;
      end
      if (strb.commit && hitMask) maskQ <= wrDataQ[FLAG_W-1:0];
    end
  end

  assign clrVec = (strb.commit && hitFlag) ? wrDataQ[FLAG_W-1:0] : '0;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[i] <= 1'b0;
      else       flagQ[i] <= pendSet[i] | (flagQ[i] & ~clrVec[i]);
    end
  end

  always_comb begin
    flagWide = '0;
    maskWide = '0;
    flagWide[FLAG_W-1:0] = flagQ;
    maskWide[FLAG_W-1:0] = maskQ;
    if (curAddr == FLAG_A)      rdMux = flagWide;
    else if (curAddr == MASK_A) rdMux = maskWide;
    else                        rdMux = regRdData;
  end

  assign dataOe    = strb.readAct;
  assign regRdEn   = strb.readAct;
  assign regRdAddr = curAddr;
  assign dataOut   = strb.readAct ? rdMux : '0;
  assign irqN      = ~|(flagQ & maskQ);
endmodule

// File: rtl/busfront.sv
module busfront
  import bif_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int FLAG_W    = 8,
  parameter int FLAG_ADDR = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              irqN,
  input  logic [FLAG_W-1:0] pendSet,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regRdAddr,
  output logic              regWrStb,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData
);
  busStrb_t strb;
  busMode_e busMode;

  bif_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .strapIn(addrIn[1:0]), .strb(strb), .busMode(busMode)
  );

  bif_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W),
    .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .dataIn(dataIn),
    .pendSet(pendSet), .regRdData(regRdData), .dataOut(dataOut),
    .dataOe(dataOe), .regRdEn(regRdEn), .regRdAddr(regRdAddr),
    .regWrStb(regWrStb), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .irqN(irqN)
  );
endmodule

// File: rtl/bif_chk.sv
module bif_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       dataOe,
  input logic       regWrStb,
  input logic [1:0] busMode
);
  // R6
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !csN);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |=> !regWrStb);

  // R5
  strobe_after_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |-> !$past(csN, 2));

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(busMode));
endmodule

bind busfront bif_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .dataOe(dataOe),
  .regWrStb(regWrStb), .busMode(busMode)
);

// File: tb/test_busfront.sv
module test_busfront;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [3:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] pendSet = '0;
  logic [7:0] regRdData;
  logic [7:0] dataOut, regWrData;
  logic       dataOe, irqN, regRdEn, regWrStb;
  logic [3:0] regRdAddr, regWrAddr;

  int nChecks = 0, nFails = 0;
  int modeSel = 0;  // 0 split, 1 strobe/direction, 2 multiplexed
  bit done = 0;
  logic [11:0] expQ[$];

  always #4 clk = ~clk;

  assign regRdData = {~regRdAddr, regRdAddr};

  busfront i_busfront (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .irqN(irqN), .pendSet(pendSet), .regRdData(regRdData),
    .regRdEn(regRdEn), .regRdAddr(regRdAddr), .regWrStb(regWrStb),
    .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every strobe must match the oldest expected write.
  always @(negedge clk) begin
    if (rstN && regWrStb) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected regWrStb", {20'd0, regWrAddr, regWrData}, 32'd0);
      end else begin
        logic [11:0] e;
        e = expQ.pop_front();
        chk({regWrAddr, regWrData} == e, "R5 write addr/data",
            {20'd0, regWrAddr, regWrData}, {20'd0, e});
      end
    end
  end

  task automatic doReset(input logic [1:0] strap, input int sel);
    @(negedge clk);
    rstN = 1'b0; csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    addrIn = {2'b00, strap};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    addrIn = {2'b01, ~strap};  // pins move: mode must not follow (R1)
    modeSel = sel;
    @(negedge clk);
    chk(dataOe == 1'b0, "R11 dataOe after reset", 32'(dataOe), 0);
    chk(regWrStb == 1'b0, "R11 regWrStb after reset", 32'(regWrStb), 0);
    chk(irqN == 1'b1, "R11 irqN after reset", 32'(irqN), 1);
  endtask

  task automatic setAddr(input logic [3:0] a);
    if (modeSel == 2) begin
      addrIn = 4'b1011; dataIn = {4'h0, a};  // R4: latch enable high
      @(negedge clk);
      addrIn = 4'b1010; dataIn = 8'hE0 | {4'h0, ~a};
      @(negedge clk);
    end else begin
      addrIn = a;
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d,
                          input bit fwd, input logic [7:0] pendAtEnd);
    @(negedge clk);
    setAddr(a);
    dataIn = d; csN = 1'b0;
    if (modeSel == 1) begin rdN = 1'b0; wrN = 1'b0; end
    else wrN = 1'b0;
    @(negedge clk);
    if (modeSel == 1) chk(dataOe == 1'b0, "R3 no drive during write", 32'(dataOe), 0);
    @(negedge clk);
    if (fwd) expQ.push_back({a, d});
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    pendSet = pendAtEnd;
    @(negedge clk);
    pendSet = '0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    setAddr(a);
    csN = 1'b0; rdN = 1'b0;
    if (modeSel == 1) wrN = 1'b1;
    #2;
    chk(dataOe && regRdEn, {tag, " oe during read"}, 32'(dataOe), 1);
    chk(dataOut == exp, {tag, " read data"}, 32'(dataOut), 32'(exp));
    chk(regRdAddr == a, {tag, " read address"}, 32'(regRdAddr), 32'(a));
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
    #2;
    chk(!dataOe && dataOut == 8'h00, "R6 released after read", 32'(dataOut), 0);
  endtask

  initial begin
    // split mode, strap 00
    doReset(2'b00, 0);
    busRead(4'h0, 8'h00, "R11 flags zero");
    busRead(4'h1, 8'h00, "R11 mask zero");
    busWrite(4'h5, 8'hA7, 1, 8'h00);
    busWrite(4'hF, 8'h3C, 1, 8'h00);
    busRead(4'h9, 8'h69, "R2 split read");
    busRead(4'h3, 8'hC3, "R2 split read");
    @(negedge clk);
    addrIn = 4'h4; rdN = 1'b0; csN = 1'b1;
    #2 chk(!dataOe && !regRdEn, "R6 no select no drive", 32'(dataOe), 0);
    rdN = 1'b1;
    @(negedge clk);
    pendSet = 8'h05;
    @(negedge clk);
    pendSet = 8'h00;
    chk(irqN == 1'b1, "R9 masked flags no irq", 32'(irqN), 1);
    busRead(4'h0, 8'h05, "R7 flags set");
    busWrite(4'h1, 8'h04, 0, 8'h00);
    chk(irqN == 1'b0, "R9 enabled flag irq", 32'(irqN), 0);
    busRead(4'h1, 8'h04, "R9 mask readback");
    busWrite(4'h0, 8'h04, 0, 8'h00);
    chk(irqN == 1'b1, "R8 clear drops irq", 32'(irqN), 1);
    busRead(4'h0, 8'h01, "R8 selective clear");
    busWrite(4'h0, 8'h01, 0, 8'h01);
    busRead(4'h0, 8'h01, "R8 set wins over clear");
    busWrite(4'h0, 8'h01, 0, 8'h00);
    busRead(4'h0, 8'h00, "R8 clear");

    // strobe/direction mode, strap 11
    doReset(2'b11, 1);
    busRead(4'h0, 8'h00, "R11 flags cleared by reset");
    busWrite(4'h7, 8'h5E, 1, 8'h00);
    busRead(4'h7, 8'h87, "R3 strobe read");
    busWrite(4'h1, 8'h80, 0, 8'h80);
    chk(irqN == 1'b0, "R9 irq in strobe mode", 32'(irqN), 0);

    // multiplexed mode, strap 10
    doReset(2'b10, 2);
    busWrite(4'h6, 8'h91, 1, 8'h00);
    busRead(4'hC, 8'h3C, "R4 latched address read");
    busRead(4'h0, 8'h00, "R4 latched local read");

    // strap 01 falls back to split mode
    doReset(2'b01, 0);
    busWrite(4'h2, 8'h11, 1, 8'h00);
    busRead(4'h4, 8'hB4, "R1 strap 01 split read");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R5 all writes strobed", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule